// File: doc/BRIEF.md
# Typed Multi-Issue Dispatch Queue

This block is an eight-entry instruction queue that sits between instruction fetch and three execution units: integer, floating-point and branch. Each entry holds an instruction word and a two-bit class tag. On every clock the block looks at the four oldest entries. For each unit that is not busy, it issues the oldest entry in that window that belongs to the unit's class. Up to three instructions can leave in one cycle, and they can come from slots that are not next to each other.

The entries that stay behind are packed toward the head in the same cycle, keeping their order. New instructions from fetch are appended behind them, up to the number of slots left free after this cycle's issue. Fetch offers a count of instructions on parallel lanes, and the block answers with the count it accepts. A synchronous flush empties the queue.

Issue is combinational from the registered queue contents and the busy inputs. Fetch acceptance and the packing of the queue take effect at the next rising clock edge.

Top module: `disp_queue`

## Requirements
- R1: After reset is released the queue is empty. All three dispatch valids are low until instructions have been accepted from fetch.
- R2: The class tag is encoded as 0 = integer, 1 = floating-point, 2 = branch. Tag value 3 is handled as branch.
- R3: Only queue positions 0 to 3 (0 is the oldest) can issue. An entry in position 4 or beyond is not issued, even when its unit is free and nothing in the window matches that unit.
- R4: For each free unit, the oldest matching entry in the window is issued. Each unit receives at most one instruction per cycle. The dispatch valid and instruction for a unit reflect the current queue contents in the same cycle.
- R5: A busy unit receives no instruction. Its busy state does not prevent other units from issuing in the same cycle, from any window positions.
- R6: After issue, the remaining entries move toward position 0 and keep their relative order. Empty positions never issue and never block other entries.
- R7: The accepted fetch count equals the smaller of the offered count (values above the lane count are treated as the lane count) and DEPTH minus occupancy plus the number issued this cycle. Lane 0 is appended first. Occupancy never exceeds DEPTH.
- R8: In a cycle with flush high, nothing is issued and nothing is accepted from fetch. The queue is empty in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Synchronous queue clear |
| fetch_num_i | input | 3 | Number of fetch lanes offered, counted from lane 0 |
| fetch_instr_i | input | 128 | Instruction words, lane k at bits [32k+31:32k] |
| fetch_cls_i | input | 8 | Class tags, lane k at bits [2k+1:2k] |
| fetch_take_o | output | 3 | Number of lanes accepted this cycle |
| int_busy_i | input | 1 | Integer unit cannot accept |
| fp_busy_i | input | 1 | Floating-point unit cannot accept |
| br_busy_i | input | 1 | Branch unit cannot accept |
| int_valid_o | output | 1 | Integer dispatch valid |
| int_instr_o | output | 32 | Integer dispatch instruction |
| fp_valid_o | output | 1 | Floating-point dispatch valid |
| fp_instr_o | output | 32 | Floating-point dispatch instruction |
| br_valid_o | output | 1 | Branch dispatch valid |
| br_instr_o | output | 32 | Branch dispatch instruction |

## Verification
The bench fills the window with one class and places a free-unit match in position 4. A design whose window is too wide would issue that entry early. Several cycles issue from non-adjacent slots, and later issue order is checked against a reference model. A design that packs entries wrongly would drop or duplicate instruction words, or issue them out of order. Fetch acceptance is checked on a full queue and on a full queue that issues one entry, which exposes an off-by-one in the free-slot count. Flush is checked for leaking an issue or an accepted lane, and tag 3 is checked to reach the branch port.

// File: rtl/disp_pkg.sv
package disp_pkg;
  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_FP  = 2'd1,
    CLS_BR  = 2'd2
  } cls_e;

  localparam int NUM_UNITS = 3;

  // tag 3 folds onto the branch class
  function automatic logic [1:0] cls_of(logic [1:0] tag);
    return tag[1] ? CLS_BR : tag;
  endfunction
endpackage

// File: rtl/disp_pick.sv
module disp_pick #(
  parameter int DEPTH = 8,
  parameter int WIN   = 4,
  parameter int UNIT  = 0,
  localparam int CW   = $clog2(DEPTH + 1),
  localparam int IDXW = $clog2(DEPTH),
  localparam int LIM  = (WIN < DEPTH) ? WIN : DEPTH
) (
  input  logic [1:0]      tag_i [DEPTH],
  input  logic [CW-1:0]   cnt_i,
  input  logic            busy_i,
  input  logic            hold_i,
  output logic            hit_o,
  output logic [IDXW-1:0] idx_o
);
  import disp_pkg::*;

  always_comb begin
    hit_o = 1'b0;
    idx_o = '0;
    // scan from the back so the oldest match wins
    for (int i = LIM - 1; i >= 0; i--) begin
      if (i < int'(cnt_i) && cls_of(tag_i[i]) == 2'(UNIT)) begin
        hit_o = 1'b1;
        idx_o = IDXW'(i);
      end
    end
    if (busy_i || hold_i) hit_o = 1'b0;
  end
endmodule

// File: rtl/disp_compact.sv
module disp_compact #(
  parameter int DEPTH   = 8,
  parameter int IW      = 32,
  parameter int FETCH_W = 4,
  localparam int IDXW   = $clog2(DEPTH),
  localparam int FNW    = $clog2(FETCH_W + 1)
) (
  input  logic [IW-1:0]    ins_i  [DEPTH],
  input  logic [1:0]       tag_i  [DEPTH],
  input  logic [DEPTH-1:0] keep_i,
  input  logic [FNW-1:0]   take_i,
  input  logic [IW-1:0]    fins_i [FETCH_W],
  input  logic [1:0]       ftag_i [FETCH_W],
  output logic [IW-1:0]    ins_o  [DEPTH],
  output logic [1:0]       tag_o  [DEPTH]
);
  always_comb begin
    int wr;
    wr = 0;
    for (int i = 0; i < DEPTH; i++) begin
      ins_o[i] = '0;
      tag_o[i] = '0;
    end
    // gather survivors in order
    for (int i = 0; i < DEPTH; i++) begin
      if (keep_i[i]) begin
        ins_o[IDXW'(wr)] = ins_i[i];
        tag_o[IDXW'(wr)] = tag_i[i];
        wr = wr + 1;
      end
    end
    // append accepted fetch lanes behind them
    for (int k = 0; k < FETCH_W; k++) begin
      if (k < int'(take_i) && (wr + k) < DEPTH) begin
        ins_o[IDXW'(wr + k)] = fins_i[k];
        tag_o[IDXW'(wr + k)] = ftag_i[k];
      end
    end
  end
endmodule

// File: rtl/disp_queue.sv
module disp_queue #(
  parameter int DEPTH   = 8,
  parameter int WIN     = 4,
  parameter int IW      = 32,
  parameter int FETCH_W = 4,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int IDXW   = $clog2(DEPTH),
  localparam int FNW    = $clog2(FETCH_W + 1)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  flush_i,
  input  logic [FNW-1:0]        fetch_num_i,
  input  logic [FETCH_W*IW-1:0] fetch_instr_i,
  input  logic [FETCH_W*2-1:0]  fetch_cls_i,
  output logic [FNW-1:0]        fetch_take_o,
  input  logic                  int_busy_i,
  input  logic                  fp_busy_i,
  input  logic                  br_busy_i,
  output logic                  int_valid_o,
  output logic [IW-1:0]         int_instr_o,
  output logic                  fp_valid_o,
  output logic [IW-1:0]         fp_instr_o,
  output logic                  br_valid_o,
  output logic [IW-1:0]         br_instr_o
);
  import disp_pkg::*;

  logic [IW-1:0]  ins_q [DEPTH];
  logic [1:0]     tag_q [DEPTH];
  logic [IW-1:0]  ins_d [DEPTH];
  logic [1:0]     tag_d [DEPTH];
  logic [CW-1:0]  cnt_q, cnt_d;

  logic [IW-1:0]  fins [FETCH_W];
  logic [1:0]     ftag [FETCH_W];

  logic [NUM_UNITS-1:0] busy, hit;
  logic [IDXW-1:0]      idx [NUM_UNITS];
  logic [DEPTH-1:0]     keep;
  logic [1:0]           ndisp;
  logic [FNW-1:0]       take;

  for (genvar k = 0; k < FETCH_W; k++) begin : g_lane
    assign fins[k] = fetch_instr_i[k*IW +: IW];
    assign ftag[k] = fetch_cls_i[k*2 +: 2];
  end

  assign busy = {br_busy_i, fp_busy_i, int_busy_i};

  for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
    disp_pick #(.DEPTH(DEPTH), .WIN(WIN), .UNIT(u)) u_pick (
      .tag_i  (tag_q),
      .cnt_i  (cnt_q),
      .busy_i (busy[u]),
      .hold_i (flush_i),
      .hit_o  (hit[u]),
      .idx_o  (idx[u])
    );
  end

  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      keep[i] = (i < int'(cnt_q));
      for (int u = 0; u < NUM_UNITS; u++)
        if (hit[u] && int'(idx[u]) == i) keep[i] = 1'b0;
    end
  end

  assign ndisp = 2'($countones(hit));

  always_comb begin
    int fr, nm, tk;
    fr = DEPTH - int'(cnt_q) + int'(ndisp);
    nm = (int'(fetch_num_i) > FETCH_W) ? FETCH_W : int'(fetch_num_i);
    tk = (nm < fr) ? nm : fr;
    take  = flush_i ? '0 : FNW'(tk);
    cnt_d = flush_i ? '0 : CW'(int'(cnt_q) - int'(ndisp) + tk);
  end

  disp_compact #(.DEPTH(DEPTH), .IW(IW), .FETCH_W(FETCH_W)) u_compact (
    .ins_i  (ins_q),
    .tag_i  (tag_q),
    .keep_i (keep),
    .take_i (take),
    .fins_i (fins),
    .ftag_i (ftag),
    .ins_o  (ins_d),
    .tag_o  (tag_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        ins_q[i] <= '0;
        tag_q[i] <= '0;
      end
    end else begin
      cnt_q <= cnt_d;
      for (int i = 0; i < DEPTH; i++) begin
        ins_q[i] <= ins_d[i];
        tag_q[i] <= tag_d[i];
      end
    end
  end

  assign fetch_take_o = take;
  assign int_valid_o  = hit[0];
  assign fp_valid_o   = hit[1];
  assign br_valid_o   = hit[2];
  assign int_instr_o  = ins_q[idx[0]];
  assign fp_instr_o   = ins_q[idx[1]];
  assign br_instr_o   = ins_q[idx[2]];
endmodule

// File: rtl/disp_queue_chk.sv
module disp_queue_chk #(
  parameter int DEPTH   = 8,
  parameter int FETCH_W = 4,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int FNW    = $clog2(FETCH_W + 1)
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic           flush_i,
  input logic           int_busy_i,
  input logic           fp_busy_i,
  input logic           br_busy_i,
  input logic           int_valid_o,
  input logic           fp_valid_o,
  input logic           br_valid_o,
  input logic [FNW-1:0] fetch_num_i,
  input logic [FNW-1:0] fetch_take_o,
  input logic [CW-1:0]  cnt_q
);
  logic [CW-1:0] nd;
  assign nd = CW'(int'(int_valid_o) + int'(fp_valid_o) + int'(br_valid_o));

  // R5
  int_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_busy_i |-> !int_valid_o);
  // R5
  fp_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fp_busy_i |-> !fp_valid_o);
  // R5
  br_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    br_busy_i |-> !br_valid_o);
  // R8
  flush_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |-> (fetch_take_o == '0 && !int_valid_o && !fp_valid_o && !br_valid_o));
  // R8
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> cnt_q == '0);
  // R7
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(cnt_q) <= DEPTH);
  // R7
  take_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_take_o <= fetch_num_i);
  // R7
  occupancy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !flush_i |=> cnt_q == CW'($past(cnt_q) - $past(nd) + CW'($past(fetch_take_o))));
  // R6
  empty_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_q == '0) |-> !(int_valid_o || fp_valid_o || br_valid_o));
endmodule

bind disp_queue disp_queue_chk #(.DEPTH(DEPTH), .FETCH_W(FETCH_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .flush_i      (flush_i),
  .int_busy_i   (int_busy_i),
  .fp_busy_i    (fp_busy_i),
  .br_busy_i    (br_busy_i),
  .int_valid_o  (int_valid_o),
  .fp_valid_o   (fp_valid_o),
  .br_valid_o   (br_valid_o),
  .fetch_num_i  (fetch_num_i),
  .fetch_take_o (fetch_take_o),
  .cnt_q        (cnt_q)
);

// File: tb/sim_disp_queue.sv
module sim_disp_queue;
  localparam int DEPTH = 8;
  localparam int WIN   = 4;
  localparam int IW    = 32;
  localparam int FW    = 4;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic           flush;
  logic [2:0]     fnum, ftake;
  logic [FW*IW-1:0] finstr;
  logic [FW*2-1:0]  fcls;
  logic           ib, fb, bb;
  logic           iv, fv, bv;
  logic [IW-1:0]  ii, fi, bi;

  disp_queue u0 (
    .clk_i(clk), .rst_ni(rst_ni), .flush_i(flush),
    .fetch_num_i(fnum), .fetch_instr_i(finstr), .fetch_cls_i(fcls),
    .fetch_take_o(ftake),
    .int_busy_i(ib), .fp_busy_i(fb), .br_busy_i(bb),
    .int_valid_o(iv), .int_instr_o(ii),
    .fp_valid_o(fv), .fp_instr_o(fi),
    .br_valid_o(bv), .br_instr_o(bi)
  );

  int n_chk = 0, n_bad = 0;
  logic [IW-1:0] m_ins [DEPTH];
  logic [1:0]    m_cls [DEPTH];
  int            m_cnt = 0;
  logic [IW-1:0] next_id = 32'h100;

  function automatic int unit_of(logic [1:0] t);
    return t[1] ? 2 : int'(t);
  endfunction

  task automatic check(bit ok, string req, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // compare outputs with the model, then advance the model
  task automatic step();
    bit ev [3];
    int ei [3];
    bit bz [3];
    logic [IW-1:0] av [3];
    bit    avl [3];
    int nd, fr, tk, nm, w;
    logic [IW-1:0] t_ins [DEPTH];
    logic [1:0]    t_cls [DEPTH];
    #1;
    bz[0] = ib; bz[1] = fb; bz[2] = bb;
    avl[0] = iv; avl[1] = fv; avl[2] = bv;
    av[0] = ii; av[1] = fi; av[2] = bi;
    nd = 0;
    for (int u = 0; u < 3; u++) begin
      ev[u] = 0; ei[u] = 0;
      if (!bz[u] && !flush)
        for (int i = 0; i < WIN && i < m_cnt; i++)
          if (unit_of(m_cls[i]) == u) begin ev[u] = 1; ei[u] = i; break; end
      if (ev[u]) nd++;
      check(avl[u] == ev[u], "R4 dispatch valid", avl[u], ev[u]);
      if (ev[u]) check(av[u] == m_ins[ei[u]], "R4 dispatch instr", av[u], m_ins[ei[u]]);
    end
    nm = (int'(fnum) > FW) ? FW : int'(fnum);
    fr = DEPTH - m_cnt + nd;
    tk = flush ? 0 : ((nm < fr) ? nm : fr);
    check(int'(ftake) == tk, "R7 fetch take", ftake, tk);
    if (flush) m_cnt = 0;
    else begin
      w = 0;
      for (int i = 0; i < m_cnt; i++) begin
        bit gone;
        gone = 0;
        for (int u = 0; u < 3; u++) if (ev[u] && ei[u] == i) gone = 1;
        if (!gone) begin t_ins[w] = m_ins[i]; t_cls[w] = m_cls[i]; w++; end
      end
      for (int k = 0; k < tk; k++) begin
        t_ins[w] = finstr[k*IW +: IW]; t_cls[w] = fcls[k*2 +: 2]; w++;
      end
      for (int i = 0; i < w; i++) begin m_ins[i] = t_ins[i]; m_cls[i] = t_cls[i]; end
      m_cnt = w;
      next_id = next_id + IW'(tk);
    end
  endtask

  // busy = {br, fp, int}; tag < 0 picks random tags
  task automatic cyc(logic [2:0] busy, bit fl, int num, int tag);
    @(negedge clk);
    {bb, fb, ib} = busy;
    flush = fl;
    fnum = 3'(num);
    for (int k = 0; k < FW; k++) begin
      finstr[k*IW +: IW] = next_id + IW'(k);
      fcls[k*2 +: 2] = (tag < 0) ? 2'($urandom_range(0, 3)) : 2'(tag);
    end
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [IW-1:0] b;
    void'($urandom(32'd4711));
    flush = 0; fnum = 0; finstr = '0; fcls = '0; {bb, fb, ib} = 3'b000;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R1: empty after reset
    cyc(3'b000, 0, 0, -1);
    check(!iv && !fv && !bv, "R1 no dispatch after reset", {iv, fv, bv}, 0);
    cyc(3'b000, 0, 3, 0);
    check(ftake == 3'd3, "R1 empty queue accepts offer", ftake, 3);
    cyc(3'b111, 1, 0, -1);

    // R3: four fp at the head, ints behind
    b = next_id;
    cyc(3'b111, 0, 4, 1);
    cyc(3'b111, 0, 4, 0);
    cyc(3'b110, 0, 0, 0);
    check(!iv, "R3 slot 4 not eligible", iv, 0);
    // R5: branch busy, fp still issues oldest
    cyc(3'b100, 0, 0, 0);
    check(fv && fi == b, "R5 fp issues with other unit busy", fi, b);
    check(!iv, "R3 int still outside window", iv, 0);
    // R4: two units from non-adjacent slots
    cyc(3'b000, 0, 0, 0);
    check(fv && fi == b + 1, "R4 oldest fp", fi, b + 1);
    check(iv && ii == b + 4, "R4 int from slot 3", ii, b + 4);
    // R6: order after packing around gaps
    cyc(3'b010, 0, 0, 0);
    check(iv && ii == b + 5, "R6 order preserved", ii, b + 5);

    // R2: tag 3 goes to branch
    cyc(3'b111, 1, 0, -1);
    b = next_id;
    cyc(3'b111, 0, 1, 3);
    cyc(3'b011, 0, 0, 0);
    check(bv && bi == b, "R2 tag 3 as branch", bi, b);

    // R7: full queue
    cyc(3'b111, 1, 0, -1);
    cyc(3'b111, 0, 4, 0);
    cyc(3'b111, 0, 4, 0);
    cyc(3'b111, 0, 3, 0);
    check(ftake == 0, "R7 full queue takes none", ftake, 0);
    cyc(3'b000, 0, 4, 0);
    check(ftake == 1, "R7 one freed slot", ftake, 1);

    // R8: flush
    cyc(3'b000, 1, 4, -1);
    check(ftake == 0 && !iv && !fv && !bv, "R8 flush cycle quiet", {ftake, iv, fv, bv}, 0);
    cyc(3'b000, 0, 0, -1);
    check(!iv && !fv && !bv, "R8 queue empty after flush", {iv, fv, bv}, 0);

    // random traffic
    for (int n = 0; n < 4000; n++) begin
      logic [2:0] bz;
      bz[0] = ($urandom_range(0, 9) < 3);
      bz[1] = ($urandom_range(0, 9) < 4);
      bz[2] = ($urandom_range(0, 9) < 3);
      cyc(bz, ($urandom_range(0, 99) < 3), $urandom_range(0, 4), -1);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule